// File: doc/BRIEF.md
# Ethernet destination address filter

This block judges whether an incoming Ethernet frame is meant for this station. The receive path hands it the six destination-address bytes of each frame, one byte per valid cycle, with a start strobe on the first byte. The block checks those bytes against a programmed 6-byte station address under a receive-mode byte. One cycle after the sixth byte it raises a one-cycle decision strobe and gives an accept or reject verdict. The frame buffer, CRC check and DMA engine downstream act on that verdict.

A generation select picks one of two rule sets. The legacy set has four match modes: none, limited, normal and promiscuous. Limited mode takes local multicast, meaning a group address whose first three bytes carry the station prefix. The legacy own-address match can also leave out the last address byte. The newer set is an enable bit, followed by either an accept-all bit or an own-address bit. The mode byte, station address and generation select are captured together with the first address byte, so a change to them partway through a frame does not affect that frame.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is held, and after it, `decision_valid` and `accept` are low until a frame's sixth address byte has been taken.
- R2: `decision_valid` is high for exactly one cycle: the cycle after the sixth valid byte of a frame is taken. `accept` is high only in that cycle, and only when the frame passes the active rule.
- R3: A byte with `byte_valid` and `sof` both high starts a new frame as byte 0 and discards any partial comparison. Valid bytes that arrive outside a frame give no decision. This covers bytes after reset with no start and bytes past the sixth.
- R4: `gen_sel`, `rx_mode` and `station_addr` are sampled in the start cycle. Changes to them during the rest of the frame do not alter its verdict.
- R5: With `gen_sel`=0, `rx_mode[1:0]`=0 rejects every frame and `rx_mode[1:0]`=3 accepts every frame.
- R6: With `gen_sel`=0, `rx_mode[1:0]`=1 (limited) accepts a frame that meets any of these:
  - it is broadcast (all six bytes 0xFF);
  - it matches the own address;
  - it is a local multicast: byte 0 bit 0 set, byte 0 with bit 0 cleared equal to station byte 0, and bytes 1 and 2 equal to station bytes 1 and 2.
- R7: With `gen_sel`=0, `rx_mode[1:0]`=2 (normal) accepts broadcast, an own-address match, or any multicast (byte 0 bit 0 set).
- R8: In the legacy own-address match, bytes 0 to 4 must equal the station bytes. Byte 5 must also match unless `rx_mode[4]` is set, in which case byte 5 is not compared.
- R9: With `gen_sel`=1, nothing is accepted while `rx_mode[7]` is 0. With `rx_mode[7]` set:
  - `rx_mode[0]` set accepts everything;
  - otherwise `rx_mode[1]` set accepts broadcast or an exact six-byte own match;
  - otherwise only broadcast is accepted.
  `rx_mode[4]` has no effect in this generation.
- R10: Station byte k is `station_addr[8k+7:8k]`. Byte 0 is the first on the wire and carries the group bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start of frame; marks byte 0 when `byte_valid` is high |
| byte_valid | input | 1 | `byte_data` holds an address byte |
| byte_data | input | 8 | Destination-address byte |
| gen_sel | input | 1 | Rule set: 0 legacy, 1 newer |
| rx_mode | input | 8 | Receive-mode byte |
| station_addr | input | 48 | Station address, byte 0 in the low bits |
| decision_valid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame accepted (meaningful with `decision_valid`) |

## Verification
Two events can fall in the same cycle. One is the verdict of one frame. The other is the start byte of the next frame, which also captures new mode and address settings. The bench provokes this by sending frames back to back with a different mode for each. It then checks that the first verdict follows the old settings and the second follows the new ones. The main sweep also scrambles the mode, address and generation inputs on every byte after the start byte. The bench compares each verdict against a reference computed from the values captured at the start byte.

// File: rtl/daf_pkg.sv
package daf_pkg;
  typedef enum logic {GEN_OLD = 1'b0, GEN_NEW = 1'b1} gen_e;

  localparam int MODE_W = 8;

  // legacy match modes in rx_mode[1:0]
  localparam logic [1:0] OM_NONE    = 2'd0;
  localparam logic [1:0] OM_LIMITED = 2'd1;
  localparam logic [1:0] OM_NORMAL  = 2'd2;
  localparam logic [1:0] OM_PROMISC = 2'd3;

  localparam int BIT_SKIP_LAST = 4;
  localparam int BIT_NEW_EN    = 7;
  localparam int BIT_NEW_ANY   = 0;
  localparam int BIT_NEW_OWN   = 1;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    gen_e              gen;
  } cfg_t;
endpackage

// File: rtl/daf_byte_seq.sv
module daf_byte_seq
  import daf_pkg::*;
#(
  parameter int NB = 6,
  parameter int BW = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int SW = NB * BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              byte_valid,
  input  gen_e              gen_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SW-1:0]     station_i,
  output logic              take,
  output logic              last,
  output logic [IW-1:0]     idx,
  output cfg_t              cfg_o,
  output logic [SW-1:0]     station_o
);
  logic          active;
  logic [IW-1:0] cnt;
  logic          start;
  cfg_t          cfg_q;
  logic [SW-1:0] station_q;

  assign start = byte_valid && sof;
  assign take  = byte_valid && (sof || active);
  assign idx   = sof ? '0 : cnt;
  assign last  = take && (idx == IW'(NB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (take) begin
      if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        active <= 1'b1;
        cnt    <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      station_q <= '0;
    end else if (start) begin
      cfg_q     <= '{mode: mode_i, gen: gen_i};
      station_q <= station_i;
    end
  end

  assign cfg_o     = cfg_q;
  assign station_o = start ? station_i : station_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= IW'(NB - 1));

  assert_idle_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    last |=> !active);

  assert_cfg_held_R4: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(cfg_q) && $stable(station_q)));
endmodule

// File: rtl/daf_match_acc.sv
module daf_match_acc #(
  parameter int NB = 6,
  parameter int BW = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int SW = NB * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [IW-1:0] idx,
  input  logic [BW-1:0] byte_i,
  input  logic [SW-1:0] station_i,
  output logic [NB-1:0] eq_now,
  output logic [NB-1:0] ff_now,
  output logic          lm0,
  output logic          grp
);
  logic hit0;
  logic lm0_q, grp_q;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic hit, eq_c, ff_c, eq_q, ff_q;
    assign hit  = take && (idx == IW'(i));
    assign eq_c = (byte_i == station_i[i*BW +: BW]);
    assign ff_c = &byte_i;

    always_ff @(posedge clk) begin
      if (rst) begin
        eq_q <= 1'b0;
        ff_q <= 1'b0;
      end else if (hit) begin
        eq_q <= eq_c;
        ff_q <= ff_c;
      end
    end

    assign eq_now[i] = hit ? eq_c : eq_q;
    assign ff_now[i] = hit ? ff_c : ff_q;
  end

  assign hit0 = take && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lm0_q <= 1'b0;
      grp_q <= 1'b0;
    end else if (hit0) begin
      lm0_q <= byte_i[0] && ({byte_i[BW-1:1], 1'b0} == station_i[BW-1:0]);
      grp_q <= byte_i[0];
    end
  end

  assign lm0 = lm0_q;
  assign grp = grp_q;
endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
#(
  parameter int NB = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          last,
  input  cfg_t          cfg,
  input  logic [NB-1:0] eq_now,
  input  logic [NB-1:0] ff_now,
  input  logic          lm0,
  input  logic          grp,
  output logic          dv_o,
  output logic          acc_o
);
  logic bcast, own_full, own_old, lmc, verdict_old, verdict_new, verdict;
  logic dv_q, acc_q;

  assign bcast    = &ff_now;
  assign own_full = &eq_now;
  assign own_old  = (&eq_now[NB-2:0]) && (eq_now[NB-1] || cfg.mode[BIT_SKIP_LAST]);
  assign lmc      = lm0 && eq_now[1] && eq_now[2];

  always_comb begin
    unique case (cfg.mode[1:0])
      OM_NONE:    verdict_old = 1'b0;
      OM_LIMITED: verdict_old = bcast || own_old || lmc;
      OM_NORMAL:  verdict_old = bcast || own_old || grp;
      default:    verdict_old = 1'b1;
    endcase
  end

  always_comb begin
    if (!cfg.mode[BIT_NEW_EN])       verdict_new = 1'b0;
    else if (cfg.mode[BIT_NEW_ANY])  verdict_new = 1'b1;
    else if (cfg.mode[BIT_NEW_OWN])  verdict_new = bcast || own_full;
    else                             verdict_new = bcast;
  end

  assign verdict = (cfg.gen == GEN_NEW) ? verdict_new : verdict_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q  <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      dv_q  <= last;
      acc_q <= last && verdict;
    end
  end

  assign dv_o  = dv_q;
  assign acc_o = acc_q;

  assert_acc_needs_dv_R2: assert property (@(posedge clk) disable iff (rst)
    acc_q |-> dv_q);

  assert_dv_single_R2: assert property (@(posedge clk) disable iff (rst)
    dv_q |=> !dv_q);

  assert_none_rejects_R5: assert property (@(posedge clk) disable iff (rst)
    (last && cfg.gen == GEN_OLD && cfg.mode[1:0] == OM_NONE) |=> !acc_q);

  assert_new_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (last && cfg.gen == GEN_NEW && !cfg.mode[BIT_NEW_EN]) |=> !acc_q);

  assert_skip_last_R8: assert property (@(posedge clk) disable iff (rst)
    (last && cfg.gen == GEN_OLD && cfg.mode[BIT_SKIP_LAST] &&
     (cfg.mode[1:0] == OM_LIMITED || cfg.mode[1:0] == OM_NORMAL) &&
     (&eq_now[NB-2:0])) |=> acc_q);
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int NB = 6,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              byte_valid,
  input  logic [BW-1:0]     byte_data,
  input  logic              gen_sel,
  input  logic [MODE_W-1:0] rx_mode,
  input  logic [NB*BW-1:0]  station_addr,
  output logic              decision_valid,
  output logic              accept
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam int SW = NB * BW;

  logic          take, last;
  logic [IW-1:0] idx;
  cfg_t          cfg;
  logic [SW-1:0] station_eff;
  logic [NB-1:0] eq_now, ff_now;
  logic          lm0, grp;
  gen_e          gen_in;

  assign gen_in = gen_e'(gen_sel);

  daf_byte_seq #(.NB(NB), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .sof(sof), .byte_valid(byte_valid),
    .gen_i(gen_in), .mode_i(rx_mode), .station_i(station_addr),
    .take(take), .last(last), .idx(idx), .cfg_o(cfg), .station_o(station_eff)
  );

  daf_match_acc #(.NB(NB), .BW(BW)) u_match (
    .clk(clk), .rst(rst), .take(take), .idx(idx), .byte_i(byte_data),
    .station_i(station_eff), .eq_now(eq_now), .ff_now(ff_now),
    .lm0(lm0), .grp(grp)
  );

  daf_decide #(.NB(NB)) u_decide (
    .clk(clk), .rst(rst), .last(last), .cfg(cfg), .eq_now(eq_now),
    .ff_now(ff_now), .lm0(lm0), .grp(grp),
    .dv_o(decision_valid), .acc_o(accept)
  );
endmodule

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        gen_sel = 1'b0;
  logic [7:0]  rx_mode = '0;
  logic [47:0] station_addr = '0;
  logic        decision_valid, accept;

  int n_tests = 0;
  int n_fail = 0;
  int dv_count = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dest_addr_filter dut (
    .clk(clk), .rst(rst), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .gen_sel(gen_sel), .rx_mode(rx_mode),
    .station_addr(station_addr), .decision_valid(decision_valid),
    .accept(accept)
  );

  always @(negedge clk) if (decision_valid) dv_count++;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference verdict taken directly from R5..R10
  function automatic bit ref_accept(logic [47:0] a, logic [47:0] st,
                                    logic [7:0] m, bit g);
    bit bc, own6, ownl, mc, lmc;
    bc   = (a == 48'hFFFF_FFFF_FFFF);
    own6 = (a == st);
    ownl = (a[39:0] == st[39:0]) && ((a[47:40] == st[47:40]) || m[4]);
    mc   = a[0];
    lmc  = a[0] && ((a[7:0] & 8'hFE) == st[7:0]) && (a[23:8] == st[23:8]);
    if (g) begin
      if (!m[7]) return 1'b0;
      if (m[0]) return 1'b1;
      if (m[1]) return bc || own6;
      return bc;
    end
    case (m[1:0])
      2'd0: return 1'b0;
      2'd1: return bc || ownl || lmc;
      2'd2: return bc || ownl || mc;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [47:0] mk_addr(int k, logic [47:0] st);
    logic [47:0] lm;
    lm = {st[47:24] ^ 24'h5A5A5A, st[23:8], st[7:0] | 8'h01};
    case (k)
      0: return 48'hFFFF_FFFF_FFFF;
      1: return st;
      2: return st ^ 48'h01_0000_0000_00;
      3: return lm;
      4: return lm ^ 48'h00_0000_10_0000;
      5: return 48'h12_3456_7890_33;
      6: return 48'hAB_CDEF_0123_40;
      7: return st ^ 48'h04;
      8: return 48'hFF_FFFF_FFFF_FE;
      default: return st ^ 48'h00_0001_0000_00;
    endcase
  endfunction

  // Sends six bytes; scramble perturbs the config after the start byte (R4).
  task automatic send_frame(logic [47:0] a, logic [47:0] st, logic [7:0] m,
                            bit g, bit scramble, string req);
    bit exp;
    exp = ref_accept(a, st, m, g);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byte_valid   = 1'b1;
      sof          = (i == 0);
      byte_data    = a[i*8 +: 8];
      station_addr = (scramble && i > 0) ? ~st : st;
      rx_mode      = (scramble && i > 0) ? ~m : m;
      gen_sel      = (scramble && i > 0) ? ~g : g;
    end
    @(negedge clk);
    byte_valid = 1'b0;
    sof = 1'b0;
    check({req, " R2 dv after sixth byte"}, int'(decision_valid), 1);
    check({req, scramble ? " R4 verdict" : " verdict"}, int'(accept), int'(exp));
    @(negedge clk);
    check("R2 dv one cycle", int'(decision_valid), 0);
  endtask

  logic [47:0] stations [3];

  initial begin
    stations[0] = 48'h56_4433_2211_02;
    stations[1] = 48'hEE_DDCC_BBAA_00;
    stations[2] = 48'h01_0203_0405_09;

    repeat (3) @(negedge clk);
    check("R1 dv in reset", int'(decision_valid), 0);
    check("R1 accept in reset", int'(accept), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dv after reset", int'(decision_valid), 0);
    check("R1 accept after reset", int'(accept), 0);

    // R3: valid bytes with no start give no decision
    begin
      int base;
      base = dv_count;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        byte_valid = 1'b1; sof = 1'b0; byte_data = 8'hFF;
      end
      @(negedge clk); byte_valid = 1'b0;
      repeat (2) @(negedge clk);
      check("R3 no decision without start", dv_count - base, 0);
    end

    // Sweep: both generations, all relevant mode bits, ten addresses, three stations
    begin
      int n;
      n = 0;
      for (int g = 0; g < 2; g++)
        for (int mi = 0; mi < 16; mi++) begin
          logic [7:0] m;
          if (g == 0 && mi >= 8) continue;
          if (g == 0) m = {3'b0, mi[2], 2'b0, mi[1:0]};
          else        m = {mi[3], 2'b0, mi[2], 2'b0, mi[1:0]};
          for (int s = 0; s < 3; s++)
            for (int k = 0; k < 10; k++) begin
              string tag;
              if (g == 1) tag = "R9";
              else if (m[4] && (k == 2)) tag = "R8";
              else if (m[1:0] == 2'd1) tag = "R6";
              else if (m[1:0] == 2'd2) tag = "R7";
              else tag = "R5";
              if (s == 2) tag = {tag, " R10"};
              send_frame(mk_addr(k, stations[s]), stations[s], m, g[0], n[0], tag);
              n++;
            end
        end
    end

    // R3: partial frame then a fresh start discards the partial compare
    begin
      int base;
      base = dv_count;
      gen_sel = 1'b0; rx_mode = 8'h02; station_addr = stations[0];
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        byte_valid = 1'b1; sof = (i == 0); byte_data = 8'hFF;
      end
      send_frame(48'hAB_CDEF_0123_40, stations[0], 8'h02, 1'b0, 1'b0, "R3 restart");
      check("R3 single decision after restart", dv_count - base, 1);
      base = dv_count;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        byte_valid = 1'b1; sof = 1'b0; byte_data = 8'hFF;
      end
      @(negedge clk); byte_valid = 1'b0;
      repeat (2) @(negedge clk);
      check("R3 bytes past sixth ignored", dv_count - base, 0);
    end

    // Back to back: verdict of frame A shares its cycle with the start of frame B
    begin
      logic [47:0] fa, fb;
      fa = 48'hFFFF_FFFF_FFFF;
      fb = stations[1];
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        byte_valid = 1'b1; sof = (i == 0); byte_data = fa[i*8 +: 8];
        gen_sel = 1'b0; rx_mode = 8'h01; station_addr = stations[0];
      end
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (i == 0) begin
          check("R2 b2b dv frame A", int'(decision_valid), 1);
          check("R6 b2b verdict frame A", int'(accept), 1);
        end else if (i == 1) begin
          check("R2 b2b dv gap", int'(decision_valid), 0);
        end
        byte_valid = 1'b1; sof = (i == 0); byte_data = fb[i*8 +: 8];
        gen_sel = 1'b1; rx_mode = 8'h80; station_addr = stations[1];
      end
      @(negedge clk);
      byte_valid = 1'b0; sof = 1'b0;
      check("R2 b2b dv frame B", int'(decision_valid), 1);
      check("R9 b2b verdict frame B (bcast only)", int'(accept), 0);
      @(negedge clk);
      check("R2 b2b dv drop", int'(decision_valid), 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule